// File: doc/BRIEF.md
# Fixed Pattern Spread Generator

This block builds one cache line of test data for a write buffer, as eight 64-bit chunks. Two small tables feed it. A burst table holds eight 8-bit bursts, and each burst has one bit for each chunk. A lane map holds 3-bit entries that pick a burst. A spread value sets how many lane map entries are used in turn across the 64 bit lanes. For chunk `c`, bit lane `b` takes bit `c` of the burst that lane map entry `b mod spread` selects. A narrow spread repeats a short group of bursts across the whole chunk. A wide spread interleaves up to eight different bursts.

Software or a sequencer first loads both tables through their write ports while the block is idle. It then pulses `start` with a spread and a target line address. The block sends chunks 0 to 7 on consecutive cycles toward the buffer write port, each with a valid strobe, the chunk index and the latched line address. In the cycle after the last chunk it raises a one-cycle completion pulse together with a pulse that tells the write port to leave its write mode.

Top module: `fixed_pat_spread_gen`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `busy`, `wr_valid`, `done` and `mode_clr` are all low.
- R2: A `start` pulse seen at a clock edge while idle makes `busy` high from the next cycle. From that cycle on, chunks are presented with `wr_valid` high on eight consecutive cycles, and `wr_chunk` counts 0,1,...,7.
- R3: In the chunk with index `c`, bit `b` of `wr_data` (b = 0..63) equals bit `c` of burst entry `m[b mod s]`. Here `m[i]` is lane map entry `i`, a 3-bit index into the burst table, and `s` is the effective spread.
- R4: The effective spread is the `spread` input sampled with `start`. A value of 0 is used as 1, values above 8 are used as 8, and changes to `spread` during a line have no effect.
- R5: Every chunk of one line carries on `wr_addr` the `line_addr` sampled with `start`. Changes to `line_addr` during the line do not change `wr_addr`.
- R6: In the cycle after chunk 7, `done` and `mode_clr` are high for exactly one cycle, and `busy` and `wr_valid` are low.
- R7: A `start` pulse while `busy` is high is ignored. The running line neither restarts nor changes its chunk order.
- R8: A burst table write (`pat_we`, entry `pat_waddr`) or a lane map write (`map_we`, entry `map_waddr`) made while idle replaces that entry. A write made while `busy` is high is dropped, and neither the running line nor later lines see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_we | input | 1 | Burst table write enable |
| pat_waddr | input | 3 | Burst table entry to write |
| pat_wdata | input | 8 | Burst value, bit c used by chunk c |
| map_we | input | 1 | Lane map write enable |
| map_waddr | input | 3 | Lane map entry to write |
| map_wdata | input | 3 | Burst table index stored in the lane map |
| start | input | 1 | Begin one line |
| spread | input | 4 | Number of lane map entries to cycle through |
| line_addr | input | 12 | Target line address |
| busy | output | 1 | A line is being produced |
| wr_valid | output | 1 | Chunk on `wr_data` is valid |
| wr_addr | output | 12 | Line address of the chunk |
| wr_chunk | output | 3 | Chunk index within the line |
| wr_data | output | 64 | Chunk data |
| done | output | 1 | One-cycle pulse after the last chunk |
| mode_clr | output | 1 | One-cycle pulse that tells the write port to leave write mode |

## Verification
The hardest case to reach from the ports is an input that arrives in the middle of a line. This covers a second `start`, a new `line_addr` and table writes made while chunks are being sent out. None of these should have any effect. The bench runs every spread code from 0 to 15 against three computed table sets. In the third chunk of each line it drives a fresh `start`, an inverted address and overwrite attempts on both tables. It then compares every later chunk and the next line against a model whose tables were never changed.

// File: rtl/fps_pkg.sv
// Shared types for the fixed pattern spread generator.
// Assumes: nothing beyond the two sequencer states.
package fps_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/fps_table.sv
// Small register table with one write port and all entries readable at once.
// Assumes: the caller gates wr_en when writes must be blocked; entries reset to zero.
module fps_table #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [WIDTH-1:0]       wr_data,
    output logic [DEPTH*WIDTH-1:0] rd_flat
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [WIDTH-1:0] entry_q;

        // Load this entry when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q <= '0;
            else if (wr_en && (wr_addr == AW'(e)))
                entry_q <= wr_data;
        end

        assign rd_flat[e*WIDTH +: WIDTH] = entry_q;
    end

endmodule

// File: rtl/fps_chunk_seq.sv
// Chunk sequencer: latches line address and effective spread on start, steps
// through the chunk indices one per cycle, then pulses completion.
// Assumes: start is ignored while a line runs; spread 0 maps to 1, above MAX_SPREAD to MAX_SPREAD.
module fps_chunk_seq
    import fps_pkg::*;
#(
    parameter int CHUNKS     = 8,
    parameter int MAX_SPREAD = 8,
    parameter int ADDR_W     = 12,
    localparam int CW        = $clog2(CHUNKS),
    localparam int SPW       = $clog2(MAX_SPREAD) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SPW-1:0]    spread,
    input  logic [ADDR_W-1:0] line_addr,
    output logic              busy,
    output logic [CW-1:0]     chunk,
    output logic [ADDR_W-1:0] line_q,
    output logic [SPW-1:0]    spread_q,
    output logic              done
);

    localparam logic [CW-1:0]  LAST_CHUNK = CW'(CHUNKS - 1);
    localparam logic [SPW-1:0] SP_MAX     = SPW'(MAX_SPREAD);

    seq_state_e     state_q;
    logic           done_q;
    logic [SPW-1:0] spread_eff;

    // Bring the requested spread into the legal range.
    always_comb begin
        if (spread == '0)
            spread_eff = SPW'(1);
        else if (spread > SP_MAX)
            spread_eff = SP_MAX;
        else
            spread_eff = spread;
    end

    // Run the idle/run state machine and the chunk counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            chunk    <= '0;
            line_q   <= '0;
            spread_q <= SPW'(1);
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q  <= SEQ_RUN;
                        chunk    <= '0;
                        line_q   <= line_addr;
                        spread_q <= spread_eff;
                    end
                end
                SEQ_RUN: begin
                    if (chunk == LAST_CHUNK) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        chunk <= chunk + CW'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (state_q == SEQ_RUN);
    assign done = done_q;

endmodule

// File: rtl/fps_lane_mux.sv
// Lane multiplexer: for each data lane picks a lane map entry by lane modulo
// spread, uses it to pick a burst, and takes the burst bit of the current chunk.
// Assumes: spread is already in 1..MAP_DEPTH; bursts are CHUNKS bits wide.
module fps_lane_mux #(
    parameter int LANES     = 64,
    parameter int CHUNKS    = 8,
    parameter int PAT_DEPTH = 8,
    parameter int MAP_DEPTH = 8,
    localparam int CW       = $clog2(CHUNKS),
    localparam int SEL_W    = $clog2(PAT_DEPTH),
    localparam int SPW      = $clog2(MAP_DEPTH) + 1,
    localparam int LW       = $clog2(LANES)
) (
    input  logic [PAT_DEPTH*CHUNKS-1:0] pat_flat,
    input  logic [MAP_DEPTH*SEL_W-1:0]  map_flat,
    input  logic [SPW-1:0]              spread,
    input  logic [CW-1:0]               chunk,
    output logic [LANES-1:0]            data
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [LW-1:0]     lane_rem;
        logic [SEL_W-1:0]  pat_sel;
        logic [CHUNKS-1:0] burst;

        // Select the burst for this lane and take the current chunk's bit.
        always_comb begin
            lane_rem = LW'(b) % LW'(spread);
            pat_sel  = map_flat[lane_rem*SEL_W +: SEL_W];
            burst    = pat_flat[pat_sel*CHUNKS +: CHUNKS];
            data[b]  = burst[chunk];
        end
    end

endmodule

// File: rtl/fixed_pat_spread_gen.sv
// Top of the fixed pattern spread generator: burst table, lane map, chunk
// sequencer and lane multiplexer; drives the buffer write port.
// Assumes: table writes are accepted only while idle; outputs are valid while busy.
module fixed_pat_spread_gen #(
    parameter int CHUNKS     = 8,
    parameter int LANES      = 64,
    parameter int PAT_DEPTH  = 8,
    parameter int MAX_SPREAD = 8,
    parameter int ADDR_W     = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pat_we,
    input  logic [$clog2(PAT_DEPTH)-1:0]      pat_waddr,
    input  logic [CHUNKS-1:0]                 pat_wdata,
    input  logic                              map_we,
    input  logic [$clog2(MAX_SPREAD)-1:0]     map_waddr,
    input  logic [$clog2(PAT_DEPTH)-1:0]      map_wdata,
    input  logic                              start,
    input  logic [$clog2(MAX_SPREAD):0]       spread,
    input  logic [ADDR_W-1:0]                 line_addr,
    output logic                              busy,
    output logic                              wr_valid,
    output logic [ADDR_W-1:0]                 wr_addr,
    output logic [$clog2(CHUNKS)-1:0]         wr_chunk,
    output logic [LANES-1:0]                  wr_data,
    output logic                              done,
    output logic                              mode_clr
);

    localparam int CW    = $clog2(CHUNKS);
    localparam int SEL_W = $clog2(PAT_DEPTH);
    localparam int SPW   = $clog2(MAX_SPREAD) + 1;

    logic [PAT_DEPTH*CHUNKS-1:0] pat_flat;
    logic [MAX_SPREAD*SEL_W-1:0] map_flat;
    logic [SPW-1:0]              spread_q;
    logic [CW-1:0]               chunk;
    logic                        busy_i;
    logic                        done_i;

    fps_table #(.DEPTH(PAT_DEPTH), .WIDTH(CHUNKS)) u_pat_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pat_we && !busy_i),
        .wr_addr (pat_waddr),
        .wr_data (pat_wdata),
        .rd_flat (pat_flat)
    );

    fps_table #(.DEPTH(MAX_SPREAD), .WIDTH(SEL_W)) u_map_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we && !busy_i),
        .wr_addr (map_waddr),
        .wr_data (map_wdata),
        .rd_flat (map_flat)
    );

    fps_chunk_seq #(
        .CHUNKS(CHUNKS), .MAX_SPREAD(MAX_SPREAD), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .spread    (spread),
        .line_addr (line_addr),
        .busy      (busy_i),
        .chunk     (chunk),
        .line_q    (wr_addr),
        .spread_q  (spread_q),
        .done      (done_i)
    );

    fps_lane_mux #(
        .LANES(LANES), .CHUNKS(CHUNKS), .PAT_DEPTH(PAT_DEPTH), .MAP_DEPTH(MAX_SPREAD)
    ) u_mux (
        .pat_flat (pat_flat),
        .map_flat (map_flat),
        .spread   (spread_q),
        .chunk    (chunk),
        .data     (wr_data)
    );

    assign busy     = busy_i;
    assign wr_valid = busy_i;
    assign wr_chunk = chunk;
    assign done     = done_i;
    assign mode_clr = done_i;

endmodule

// File: rtl/fps_chk.sv
// Protocol checker for the generator's write-port side, bound to the top.
// Assumes: the same reset and clock as the top module.
module fps_chk #(
    parameter int CHUNKS = 8,
    parameter int ADDR_W = 12,
    localparam int CW    = $clog2(CHUNKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CW-1:0]     wr_chunk,
    input logic              done,
    input logic              mode_clr
);

    localparam logic [CW-1:0] LAST = CW'(CHUNKS - 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !busy && !wr_valid && !done);

    // R2
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (wr_valid && wr_chunk == '0));

    // R7
    chunk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_chunk != LAST) |=> (wr_valid && wr_chunk == $past(wr_chunk) + CW'(1)));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_chunk != LAST) |=> $stable(wr_addr));

    // R6
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_chunk == LAST) |=> (done && mode_clr && !busy));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind fixed_pat_spread_gen fps_chk #(.CHUNKS(CHUNKS), .ADDR_W(ADDR_W)) u_fps_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_chunk (wr_chunk),
    .done     (done),
    .mode_clr (mode_clr)
);

// File: tb/sim_fixed_pat_spread_gen.sv
module sim_fixed_pat_spread_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we = 1'b0;
    logic [2:0]  pat_waddr = '0;
    logic [7:0]  pat_wdata = '0;
    logic        map_we = 1'b0;
    logic [2:0]  map_waddr = '0;
    logic [2:0]  map_wdata = '0;
    logic        start = 1'b0;
    logic [3:0]  spread = '0;
    logic [11:0] line_addr = '0;
    logic        busy, wr_valid, done, mode_clr;
    logic [11:0] wr_addr;
    logic [2:0]  wr_chunk;
    logic [63:0] wr_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] pat_m [8];
    logic [2:0] map_m [8];

    always #10 clk = ~clk;

    fixed_pat_spread_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata),
        .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
        .start(start), .spread(spread), .line_addr(line_addr),
        .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_chunk(wr_chunk), .wr_data(wr_data),
        .done(done), .mode_clr(mode_clr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_chunk(input int c, input int eff);
        logic [63:0] d;
        for (int b = 0; b < 64; b++) d[b] = pat_m[map_m[b % eff]][c];
        return d;
    endfunction

    task automatic load_tables(input int k);
        for (int i = 0; i < 8; i++) begin
            pat_m[i] = 8'((i * 37 + k * 91 + 13) ^ (k * 8'h5a));
            map_m[i] = 3'((i * (2 * k + 3) + k) % 8);
            @(negedge clk);
            pat_we = 1'b1; pat_waddr = 3'(i); pat_wdata = pat_m[i];
            map_we = 1'b1; map_waddr = 3'(i); map_wdata = map_m[i];
        end
        @(negedge clk);
        pat_we = 1'b0; map_we = 1'b0;
    endtask

    task automatic run_line(input int sp, input logic [11:0] addr);
        int eff;
        eff = (sp == 0) ? 1 : (sp > 8) ? 8 : sp;
        @(negedge clk);
        start = 1'b1; spread = 4'(sp); line_addr = addr;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 8; c++) begin
            // R2 chunk order, R3 data, R4 effective spread, R5 address
            check(wr_valid && busy && wr_chunk == 3'(c), "R2", {61'd0, wr_chunk}, 64'(c));
            check(wr_data == expect_chunk(c, eff), "R3/R4 data", wr_data, expect_chunk(c, eff));
            check(wr_addr == addr, "R5", 64'(wr_addr), 64'(addr));
            if (c == 2) begin
                // R7 restart attempt, R5 address change, R4 spread change, R8 blocked writes
                start = 1'b1; line_addr = ~addr; spread = 4'(sp + 3);
                pat_we = 1'b1; pat_waddr = 3'(map_m[0]); pat_wdata = ~pat_m[map_m[0]];
                map_we = 1'b1; map_waddr = 3'd0; map_wdata = map_m[0] + 3'd1;
            end else begin
                start = 1'b0; pat_we = 1'b0; map_we = 1'b0;
            end
            @(negedge clk);
        end
        // R6 completion pulse
        check(done && mode_clr && !busy && !wr_valid, "R6",
              {60'd0, done, mode_clr, busy, wr_valid}, 64'b1100);
        @(negedge clk);
        // R7 no restart from the ignored start
        check(!done && !busy && !wr_valid, "R7 idle after line",
              {61'd0, done, busy, wr_valid}, 64'd0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !wr_valid && !done && !mode_clr, "R1",
              {60'd0, busy, wr_valid, done, mode_clr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_valid, "R1 after release", {62'd0, busy, wr_valid}, 64'd0);
        for (int k = 0; k < 3; k++) begin
            load_tables(k); // R8 idle writes take effect
            for (int sp = 0; sp < 16; sp++)
                run_line(sp, 12'((k * 16 + sp) * 37 + 5));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule